// File: doc/BRIEF.md
# Burst Sample Frame Checker

This block runs one burst acquisition from an inertial sensor behind a byte-wide serial shifter. A one-cycle trigger makes it select the sensor and send a four-byte burst request. The request byte depends on a mode input, which picks either rate-and-acceleration samples or integrated delta samples. After the request the block releases the select for a fixed number of clock cycles. It then selects the sensor again and takes in a reply of twelve 32-bit words, one byte at a time.

Each reply word arrives most significant byte first. Word 0 is a status header. Its integrity is checked by a nibble-fold checksum and by a two-bit health code. Words 0 through 9 go through a CRC-32 engine that consumes one byte per clock, taking each word least significant byte first. The result is compared with word 11. Only when both checks pass are words 3 through 9 (temperature, then six axis samples) sent on a valid/last stream. A failed burst produces no stream words and raises one single-cycle error flag that names the failing level.

Top module: `bsc_burst_checker`

## Requirements
- R1: The request is sent as four bytes: 0x00, 0x00, then the mode byte (0x0A when `mode_i` is 0, 0x0B when it is 1), then a byte whose high nibble is zero and whose low nibble is 0xA XOR-folded with the mode byte's two nibbles (0x0 for mode 0, 0x1 for mode 1). A byte is only taken on a cycle where `tx_valid_o` and `tx_ready_i` are both high, and it holds steady while it waits.
- R2: `cs_o` is high while the request is being sent. It is low for exactly GAP_CYCLES clock cycles after the last request byte is accepted, and then high again while the reply is being received.
- R3: The reply is taken from `rx_byte_i` on cycles where `rx_valid_i` is high and `cs_o` is high with `tx_valid_o` low. Idle cycles between bytes are allowed. Exactly 48 bytes are assembled into 12 words, each with its first byte as bits 31:24.
- R4: The header is bad when its bits 3:0 differ from 0xA XORed with the seven nibbles in bits 31:4.
- R5: The header is also bad when its health code in bits 7:6 is 2 or 3. Codes 0 and 1 are accepted.
- R6: The CRC-32 uses reflected polynomial 0xEDB88320, a start value of all ones and a final inversion. It runs over words 0 to 9, each taken least significant byte first. A burst whose result differs from word 11 is a CRC failure.
- R7: A burst that passes both checks drives `out_valid_o` for seven consecutive cycles, carrying words 3 to 9 in order. `out_last_o` is high only with the seventh word.
- R8: A failed burst produces no stream word and pulses exactly one error output for one cycle. `hdr_err_o` takes priority over `crc_err_o` when both checks fail.
- R9: A trigger that arrives while a burst is in progress is ignored and does not start a further burst.
- R10: After reset `cs_o`, `tx_valid_o`, `out_valid_o`, `hdr_err_o` and `crc_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst trigger, used only when idle |
| mode_i | input | 1 | Burst kind: 0 rate/acceleration, 1 delta values |
| cs_o | output | 1 | Sensor select for the external shifter |
| tx_valid_o | output | 1 | Request byte valid |
| tx_ready_i | input | 1 | Shifter accepts the request byte |
| tx_byte_o | output | 8 | Request byte |
| rx_valid_i | input | 1 | Received reply byte valid |
| rx_byte_i | input | 8 | Received reply byte |
| out_valid_o | output | 1 | Stream word valid |
| out_last_o | output | 1 | Final stream word of the burst |
| out_data_o | output | 32 | Stream word |
| hdr_err_o | output | 1 | Header check failure pulse |
| crc_err_o | output | 1 | Payload CRC failure pulse |

## Verification
Several properties are checked on every cycle. A stalled request byte must hold steady. Assembled words must never come on back-to-back cycles. A word must never reach the CRC engine while it is still busy with an earlier word. The stream must run with no holes and end right after its last flag. An error pulse must last one cycle and must not be followed by stream data. Other behaviour only shows up in the directed scenarios, because it depends on a whole frame: the exact request bytes for each mode, the length of the select gap, the full header and CRC verdicts, which error wins when both checks fail, and the dropping of a trigger that arrives mid-burst.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_GAP,
      ST_READ,
      ST_SETTLE,
      ST_EMIT
   } bsc_state_e;

   localparam logic [3:0] NIB_SEED = 4'hA;

   // XOR fold of seven nibbles into the seed value
   function automatic logic [3:0] nib_fold(input logic [27:0] upper);
      logic [3:0] acc;
      acc = NIB_SEED;
      for (int i = 0; i < 7; i++) begin
         acc = acc ^ upper[i*4 +: 4];
      end
      return acc;
   endfunction

   // one byte through a reflected CRC-32 register
   function automatic logic [31:0] crc32_step(input logic [31:0] crc,
                                              input logic [7:0]  data,
                                              input logic [31:0] poly);
      logic [31:0] c;
      c = crc ^ {24'h000000, data};
      for (int b = 0; b < 8; b++) begin
         c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/bsc_cmd_gen.sv
module bsc_cmd_gen
   import bsc_pkg::*;
#(
   parameter logic [7:0] CMD_MODE0 = 8'h0A,
   parameter logic [7:0] CMD_MODE1 = 8'h0B
) (
   input  logic       mode_i,
   input  logic [1:0] idx_i,
   output logic [7:0] byte_o
);

   logic [7:0] cmd;
   logic [3:0] chk;

   assign cmd = mode_i ? CMD_MODE1 : CMD_MODE0;
   assign chk = nib_fold({8'h00, cmd, 12'h000});

   always_comb begin
      case (idx_i)
         2'd2:    byte_o = cmd;
         2'd3:    byte_o = {4'h0, chk};
         default: byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/bsc_word_packer.sv
module bsc_word_packer #(
   parameter int N_WORDS = 12,
   parameter int WIDX_W  = $clog2(N_WORDS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   output logic              word_vld_o,
   output logic [31:0]       word_o,
   output logic [WIDX_W-1:0] widx_o
);

   localparam int NBYTES = N_WORDS * 4;
   localparam int CNT_W  = $clog2(NBYTES + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [23:0]       acc_q;
   logic              take;
   logic              word_vld_q;
   logic [31:0]       word_q;
   logic [WIDX_W-1:0] widx_q;

   assign take = en_i && byte_vld_i && (cnt_q != CNT_W'(NBYTES));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         acc_q      <= '0;
         word_vld_q <= 1'b0;
         word_q     <= '0;
         widx_q     <= '0;
      end else begin
         word_vld_q <= 1'b0;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (take) begin
            acc_q <= {acc_q[15:0], byte_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q[1:0] == 2'd3) begin
               word_vld_q <= 1'b1;
               word_q     <= {acc_q, byte_i};
               widx_q     <= WIDX_W'(cnt_q >> 2);
            end
         end
      end
   end

   assign word_vld_o = word_vld_q;
   assign word_o     = word_q;
   assign widx_o     = widx_q;

   // with at most one byte per clock, words are at least four cycles apart
   assert_word_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_q |=> !word_vld_q);

endmodule

// File: rtl/bsc_crc32_bytewise.sv
module bsc_crc32_bytewise
   import bsc_pkg::*;
#(
   parameter logic [31:0] POLY      = 32'hEDB88320,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        clr_i,
   input  logic        load_i,
   input  logic [31:0] word_i,
   output logic        idle_o,
   output logic [31:0] crc_o
);

   logic [31:0] crc_q;
   logic [31:0] sh_q;
   logic [2:0]  cnt_q;
   logic [7:0]  feed;
   logic [31:0] sh_adv;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign feed   = sh_q[7:0];
         assign sh_adv = {8'h00, sh_q[31:8]};
      end else begin : g_msb_first
         assign feed   = sh_q[31:24];
         assign sh_adv = {sh_q[23:0], 8'h00};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crc_q <= '1;
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         crc_q <= '1;
         sh_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (cnt_q != 3'd0) begin
            crc_q <= crc32_step(crc_q, feed, POLY);
            sh_q  <= sh_adv;
            cnt_q <= cnt_q - 3'd1;
         end
         if (load_i) begin
            sh_q  <= word_i;
            cnt_q <= 3'd4;
         end
      end
   end

   assign idle_o = (cnt_q == 3'd0) && !load_i;
   assign crc_o  = ~crc_q;

   // a new word may only arrive while the last byte of the previous one drains
   assert_crc_no_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (cnt_q <= 3'd1));

endmodule

// File: rtl/bsc_payload_buf.sv
module bsc_payload_buf #(
   parameter int N_OUT  = 7,
   parameter int FIRST  = 3,
   parameter int WIDX_W = 4,
   parameter int OIDX_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_vld_i,
   input  logic [WIDX_W-1:0] wr_idx_i,
   input  logic [31:0]       wr_word_i,
   input  logic [OIDX_W-1:0] rd_idx_i,
   output logic [31:0]       rd_word_o
);

   logic [N_OUT*32-1:0] flat;

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_slot
         logic [31:0] val_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               val_q <= '0;
            end else if (wr_vld_i && (wr_idx_i == WIDX_W'(FIRST + k))) begin
               val_q <= wr_word_i;
            end
         end
         assign flat[k*32 +: 32] = val_q;
      end
   endgenerate

   always_comb begin
      rd_word_o = '0;
      for (int k = 0; k < N_OUT; k++) begin
         if (int'(rd_idx_i) == k) begin
            rd_word_o = flat[k*32 +: 32];
         end
      end
   end

endmodule

// File: rtl/bsc_burst_checker.sv
module bsc_burst_checker
   import bsc_pkg::*;
#(
   parameter int          GAP_CYCLES = 400,
   parameter int          N_WORDS    = 12,
   parameter int          CRC_WORDS  = 10,
   parameter int          FIRST_OUT  = 3,
   parameter int          N_OUT      = 7,
   parameter logic [7:0]  CMD_MODE0  = 8'h0A,
   parameter logic [7:0]  CMD_MODE1  = 8'h0B,
   parameter logic [31:0] CRC_POLY   = 32'hEDB88320,
   parameter bit          LSB_FIRST  = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        start_i,
   input  logic        mode_i,
   output logic        cs_o,
   output logic        tx_valid_o,
   input  logic        tx_ready_i,
   output logic [7:0]  tx_byte_o,
   input  logic        rx_valid_i,
   input  logic [7:0]  rx_byte_i,
   output logic        out_valid_o,
   output logic        out_last_o,
   output logic [31:0] out_data_o,
   output logic        hdr_err_o,
   output logic        crc_err_o
);

   localparam int WIDX_W = $clog2(N_WORDS);
   localparam int OIDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
   localparam int GAP_W  = $clog2(GAP_CYCLES + 1);

   initial begin : p_param_check
      assert_params_ok: assert (GAP_CYCLES >= 1 && N_OUT >= 2 &&
                                CRC_WORDS < N_WORDS &&
                                FIRST_OUT + N_OUT <= CRC_WORDS)
         else $error("bsc_burst_checker: inconsistent parameters");
   end

   bsc_state_e        state_q;
   logic              mode_q;
   logic [1:0]        cmd_idx_q;
   logic [GAP_W-1:0]  gap_cnt_q;
   logic [OIDX_W-1:0] emit_idx_q;
   logic              hdr_bad_q;
   logic [31:0]       exp_crc_q;
   logic              hdr_err_q;
   logic              crc_err_q;

   logic              frame_clr;
   logic              word_vld;
   logic [31:0]       word;
   logic [WIDX_W-1:0] widx;
   logic              crc_load;
   logic              crc_idle;
   logic [31:0]       crc_val;
   logic              hdr_ok;
   logic              in_read;

   assign frame_clr = (state_q == ST_IDLE) && start_i;
   assign in_read   = (state_q == ST_READ);

   // request byte source
   bsc_cmd_gen #(
      .CMD_MODE0 (CMD_MODE0),
      .CMD_MODE1 (CMD_MODE1)
   ) i_cmd (
      .mode_i (mode_q),
      .idx_i  (cmd_idx_q),
      .byte_o (tx_byte_o)
   );

   // reply bytes to words
   bsc_word_packer #(
      .N_WORDS (N_WORDS),
      .WIDX_W  (WIDX_W)
   ) i_pack (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (frame_clr),
      .en_i       (in_read),
      .byte_vld_i (rx_valid_i),
      .byte_i     (rx_byte_i),
      .word_vld_o (word_vld),
      .word_o     (word),
      .widx_o     (widx)
   );

   assign crc_load = in_read && word_vld && (widx < WIDX_W'(CRC_WORDS));

   bsc_crc32_bytewise #(
      .POLY      (CRC_POLY),
      .LSB_FIRST (LSB_FIRST)
   ) i_crc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (frame_clr),
      .load_i (crc_load),
      .word_i (word),
      .idle_o (crc_idle),
      .crc_o  (crc_val)
   );

   bsc_payload_buf #(
      .N_OUT  (N_OUT),
      .FIRST  (FIRST_OUT),
      .WIDX_W (WIDX_W),
      .OIDX_W (OIDX_W)
   ) i_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_vld_i  (in_read && word_vld),
      .wr_idx_i  (widx),
      .wr_word_i (word),
      .rd_idx_i  (emit_idx_q),
      .rd_word_o (out_data_o)
   );

   // header: nibble fold over bits 31:4, health code in bits 7:6
   assign hdr_ok = (word[3:0] == nib_fold(word[31:4])) && !word[7];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         mode_q     <= 1'b0;
         cmd_idx_q  <= '0;
         gap_cnt_q  <= '0;
         emit_idx_q <= '0;
         hdr_bad_q  <= 1'b0;
         exp_crc_q  <= '0;
         hdr_err_q  <= 1'b0;
         crc_err_q  <= 1'b0;
      end else begin
         hdr_err_q <= 1'b0;
         crc_err_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q    <= mode_i;
                  cmd_idx_q <= '0;
                  hdr_bad_q <= 1'b0;
                  state_q   <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (tx_ready_i) begin
                  if (cmd_idx_q == 2'd3) begin
                     gap_cnt_q <= GAP_W'(GAP_CYCLES - 1);
                     state_q   <= ST_GAP;
                  end else begin
                     cmd_idx_q <= cmd_idx_q + 2'd1;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt_q == '0) begin
                  state_q <= ST_READ;
               end else begin
                  gap_cnt_q <= gap_cnt_q - 1'b1;
               end
            end
            ST_READ: begin
               if (word_vld) begin
                  if (widx == '0) begin
                     hdr_bad_q <= !hdr_ok;
                  end
                  if (widx == WIDX_W'(N_WORDS - 1)) begin
                     exp_crc_q <= word;
                     state_q   <= ST_SETTLE;
                  end
               end
            end
            ST_SETTLE: begin
               if (crc_idle) begin
                  if (hdr_bad_q) begin
                     hdr_err_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else if (crc_val != exp_crc_q) begin
                     crc_err_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else begin
                     emit_idx_q <= '0;
                     state_q    <= ST_EMIT;
                  end
               end
            end
            ST_EMIT: begin
               if (emit_idx_q == OIDX_W'(N_OUT - 1)) begin
                  state_q <= ST_IDLE;
               end else begin
                  emit_idx_q <= emit_idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_o        = (state_q == ST_CMD) || (state_q == ST_READ);
   assign tx_valid_o  = (state_q == ST_CMD);
   assign out_valid_o = (state_q == ST_EMIT);
   assign out_last_o  = (state_q == ST_EMIT) && (emit_idx_q == OIDX_W'(N_OUT - 1));
   assign hdr_err_o   = hdr_err_q;
   assign crc_err_o   = crc_err_q;

   assert_cmd_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

   assert_stream_no_hole_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_last_o) |=> out_valid_o);

   assert_stream_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_last_o |=> !out_valid_o);

   assert_hdr_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hdr_err_o |=> (!hdr_err_o && !crc_err_o && !out_valid_o));

   assert_crc_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crc_err_o |=> (!crc_err_o && !hdr_err_o && !out_valid_o));

endmodule

// File: tb/test_bsc_burst_checker.sv
module test_bsc_burst_checker;

   localparam int          CLK_PERIOD = 10;
   localparam int          GAP        = 20;
   localparam logic [31:0] POLY       = 32'hEDB88320;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic        mode_i = 1'b0;
   logic        cs_o;
   logic        tx_valid_o;
   logic        tx_ready_i = 1'b0;
   logic [7:0]  tx_byte_o;
   logic        rx_valid_i = 1'b0;
   logic [7:0]  rx_byte_i = 8'h00;
   logic        out_valid_o;
   logic        out_last_o;
   logic [31:0] out_data_o;
   logic        hdr_err_o;
   logic        crc_err_o;

   bsc_burst_checker #(.GAP_CYCLES(GAP)) i_bsc_burst_checker (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .cs_o        (cs_o),
      .tx_valid_o  (tx_valid_o),
      .tx_ready_i  (tx_ready_i),
      .tx_byte_o   (tx_byte_o),
      .rx_valid_i  (rx_valid_i),
      .rx_byte_i   (rx_byte_i),
      .out_valid_o (out_valid_o),
      .out_last_o  (out_last_o),
      .out_data_o  (out_data_o),
      .hdr_err_o   (hdr_err_o),
      .crc_err_o   (crc_err_o)
   );

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   int          n_tests = 0;
   int          n_fail  = 0;
   bit          finished = 1'b0;
   int          cyc = 0;

   logic [31:0] frame_w [12];
   logic [31:0] out_q   [16];
   int          stamp_q [16];
   int          out_n, last_idx, hdr_n, crc_n;
   logic [7:0]  cmd_got [4];
   int          gap_len;
   bit          cs_bad;

   always @(negedge clk_i) begin
      cyc = cyc + 1;
      if (out_valid_o && out_n < 16) begin
         out_q[out_n]   = out_data_o;
         stamp_q[out_n] = cyc;
         if (out_last_o) last_idx = out_n;
         out_n = out_n + 1;
      end
      if (hdr_err_o) hdr_n = hdr_n + 1;
      if (crc_err_o) crc_n = crc_n + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] make_hdr(input logic [15:0] d, input logic [1:0] sv);
      logic [31:0] w;
      logic [3:0]  x;
      w = {d, 8'h5C, sv, 2'b10, 4'h0};
      x = 4'hA;
      for (int i = 1; i < 8; i++) x = x ^ w[i*4 +: 4];
      w[3:0] = x;
      return w;
   endfunction

   function automatic logic [31:0] ref_crc();
      logic [31:0] c;
      logic [7:0]  b;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 4; j++) begin
            b = frame_w[i][8*j +: 8];
            c = c ^ {24'h0, b};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
         end
      end
      return ~c;
   endfunction

   task automatic build_frame(input logic [15:0] seed, input logic [1:0] sv);
      frame_w[0] = make_hdr(seed, sv);
      for (int i = 1; i < 11; i++) frame_w[i] = {seed, 16'h0000} ^ (32'h1F3D5B79 * i);
      frame_w[11] = ref_crc();
   endtask

   task automatic run_frame(input bit mode, input bit stall_tx, input bit gap_rx,
                            input bit start_mid);
      int got;
      out_n = 0; last_idx = -1; hdr_n = 0; crc_n = 0; gap_len = 0; cs_bad = 1'b0;
      @(negedge clk_i);
      mode_i  = mode;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      got = 0;
      while (got < 4) begin
         @(negedge clk_i);
         tx_ready_i = !(stall_tx && (cyc % 3 == 1));
         if (tx_valid_o && tx_ready_i) begin
            if (!cs_o) cs_bad = 1'b1;
            cmd_got[got] = tx_byte_o;
            got++;
         end
      end
      @(negedge clk_i);
      tx_ready_i = 1'b0;
      while (!cs_o && gap_len < 10 * GAP) begin
         gap_len++;
         @(negedge clk_i);
      end
      for (int i = 0; i < 48; i++) begin
         if (gap_rx && (i % 5 == 2)) begin
            rx_valid_i = 1'b0;
            @(negedge clk_i);
         end
         rx_valid_i = 1'b1;
         rx_byte_i  = frame_w[i/4][31 - 8*(i%4) -: 8];
         start_i    = start_mid && (i == 20);
         @(negedge clk_i);
         start_i    = 1'b0;
      end
      rx_valid_i = 1'b0;
      repeat (30) @(negedge clk_i);
   endtask

   task automatic check_link(input bit mode, input string tag);
      logic [7:0] eb2, eb3;
      eb2 = mode ? 8'h0B : 8'h0A;
      eb3 = mode ? 8'h01 : 8'h00;
      check(cmd_got[0] == 8'h00 && cmd_got[1] == 8'h00 && cmd_got[2] == eb2 &&
            cmd_got[3] == eb3, "R1", {tag, " request bytes"},
            {cmd_got[0], cmd_got[1], cmd_got[2], cmd_got[3]}, {16'h0000, eb2, eb3});
      check(!cs_bad, "R2", {tag, " select during request"}, 32'(cs_bad), 0);
      check(gap_len == GAP, "R2", {tag, " select gap length"}, gap_len, GAP);
   endtask

   task automatic check_ok(input string tag);
      bit words_ok, run_ok;
      words_ok = (out_n == 7);
      run_ok   = (out_n == 7);
      for (int k = 0; k < 7 && k < out_n; k++) begin
         if (out_q[k] != frame_w[3+k]) words_ok = 1'b0;
         if (k > 0 && stamp_q[k] != stamp_q[k-1] + 1) run_ok = 1'b0;
      end
      check(out_n == 7, "R7", {tag, " stream word count"}, out_n, 7);
      check(words_ok, "R7", {tag, " words 3..9 in order"}, out_q[0], frame_w[3]);
      check(run_ok && last_idx == 6, "R7", {tag, " consecutive, last on seventh"}, last_idx, 6);
      check(hdr_n == 0 && crc_n == 0, "R8", {tag, " no error on good burst"},
            {hdr_n[15:0], crc_n[15:0]}, 0);
   endtask

   task automatic check_err(input bit exp_hdr, input string req, input string tag);
      check(out_n == 0, "R8", {tag, " no stream words"}, out_n, 0);
      check(hdr_n == int'(exp_hdr) && crc_n == int'(!exp_hdr), req,
            {tag, " error flag"}, {hdr_n[15:0], crc_n[15:0]},
            {15'h0, exp_hdr, 15'h0, !exp_hdr});
   endtask

   task automatic t_reset();
      check(!cs_o && !tx_valid_o && !out_valid_o && !hdr_err_o && !crc_err_o, "R10",
            "reset outputs", {27'h0, cs_o, tx_valid_o, out_valid_o, hdr_err_o, crc_err_o}, 0);
   endtask

   task automatic t_inertial_ok();
      build_frame(16'h1234, 2'd0);
      run_frame(1'b0, 1'b1, 1'b0, 1'b0);
      check_link(1'b0, "mode0");
      check_ok("R6 mode0");
   endtask

   task automatic t_delta_ok();
      build_frame(16'hBEEF, 2'd0);
      run_frame(1'b1, 1'b0, 1'b1, 1'b0);
      check_link(1'b1, "mode1 R3 byte gaps");
      check_ok("R3 mode1");
   endtask

   task automatic t_sv_one_ok();
      build_frame(16'h0F0F, 2'd1);
      run_frame(1'b0, 1'b0, 1'b0, 1'b0);
      check_ok("R5 health code 1 accepted");
   endtask

   task automatic t_bad_fold();
      build_frame(16'h4242, 2'd0);
      frame_w[0][3:0] = frame_w[0][3:0] ^ 4'h5;
      frame_w[11] = ref_crc();
      run_frame(1'b0, 1'b0, 1'b0, 1'b0);
      check_err(1'b1, "R4", "R4 bad nibble fold");
   endtask

   task automatic t_bad_sv();
      build_frame(16'h7777, 2'd2);
      run_frame(1'b1, 1'b0, 1'b0, 1'b0);
      check_err(1'b1, "R5", "R5 health code 2");
   endtask

   task automatic t_bad_crc();
      build_frame(16'hA5A5, 2'd0);
      frame_w[11] = frame_w[11] ^ 32'h0000_0100;
      run_frame(1'b0, 1'b0, 1'b1, 1'b0);
      check_err(1'b0, "R6", "R6 crc mismatch");
   endtask

   task automatic t_both_bad();
      build_frame(16'h3C3C, 2'd3);
      frame_w[11] = frame_w[11] ^ 32'h8000_0000;
      run_frame(1'b0, 1'b0, 1'b0, 1'b0);
      check_err(1'b1, "R8", "R8 header wins over crc");
   endtask

   task automatic t_start_ignored();
      build_frame(16'h5151, 2'd0);
      run_frame(1'b0, 1'b0, 1'b0, 1'b1);
      check_ok("R9 mid-burst trigger");
      check(!cs_o && !tx_valid_o, "R9", "no second burst started",
            {30'h0, cs_o, tx_valid_o}, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);
      t_reset();
      t_inertial_ok();
      t_delta_ok();
      t_sv_one_ok();
      t_bad_fold();
      t_bad_sv();
      t_bad_crc();
      t_both_bad();
      t_start_ignored();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule